// File: doc/BRIEF.md
# Multi-Region Instruction Fetch Sequencer

This block keeps the 20-bit byte-addressed program counter of a small processor core. It sends each instruction fetch to one of three stores. Two are private to the core: the register RAM and the lookup RAM, each addressed by a long (32-bit word) index. The third is the shared main memory, which is addressed by byte and read through a streaming port with a valid handshake. Byte addresses below `0x01000` form the local window. The long index is the PC shifted right by two. Indices below `0x200` are register RAM, and indices `0x200` to `0x3FF` are lookup RAM. Addresses at `0x01000` and above go to main memory.

A state machine steps through the states ISSUE, LREQ, LDATA, HWAIT and HALT. ISSUE decodes the PC. If the PC falls in the eight reserved registers, ISSUE moves to HALT. For a local address it moves to LREQ. For main memory it moves to HWAIT. LREQ always moves to LDATA. LDATA moves to ISSUE, or to HALT when the long just delivered was the last lookup long. HWAIT moves to ISSUE when the port reports valid data, and otherwise stays in HWAIT. HALT stays in HALT. From any state, an accepted branch moves to ISSUE.

Sequential code runs from the top of register RAM straight into lookup RAM with no branch. The core restarts fetching after an error by branching.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held and after it is released, `instr_valid` and all three error flags read 0. The first request after reset goes to main memory with `hub_addr` = `0x01000`.
- R2: For a PC below `0x01000`, the long index is `PC[11:2]`. An index from `0x008` to `0x1FF` raises `reg_req` with `loc_idx` set to the index. An index from `0x200` to `0x3FF` raises `lut_req` with `loc_idx` set to the index minus `0x200`.
- R3: At most one of `reg_req`, `lut_req` and `hub_req` is high in any cycle.
- R4: Local read data is taken from `reg_rdata` or `lut_rdata` in the cycle after the request. It appears on `instr`, with `instr_pc` and a one-cycle `instr_valid` pulse, in the cycle after that.
- R5: After each delivered instruction the PC advances by 4. Execution from byte `0x7FC` continues at `0x800`, which is lookup index 0.
- R6: A fetch from long index `0x000`–`0x007` sets `err_sfr`. It raises no request and delivers no instruction until a branch is accepted.
- R7: The instruction at `0xFFC` is delivered, and `err_bound` rises in the same cycle. No further request or instruction follows until a branch is accepted.
- R8: A PC at or above `0x01000` raises `hub_req` with `hub_addr` equal to the PC, and the PC need not be aligned. `hub_req` and `hub_addr` hold until `hub_valid`. The instruction delivered is `hub_rdata` from that cycle.
- R9: A branch target below `0x01000` with nonzero bits [1:0] sets `err_misalign`. The PC is not loaded, the state does not change, and the other flags are kept.
- R10: A branch with an acceptable target drops any fetch in flight and clears all error flags. Fetching restarts from the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch request, one cycle |
| br_target | input | 20 | Branch target byte address |
| reg_req | output | 1 | Register RAM read request |
| lut_req | output | 1 | Lookup RAM read request |
| loc_idx | output | 9 | Long index into the selected local RAM |
| reg_rdata | input | 32 | Register RAM read data, one cycle after request |
| lut_rdata | input | 32 | Lookup RAM read data, one cycle after request |
| hub_req | output | 1 | Main memory streaming read request |
| hub_addr | output | 20 | Main memory byte address |
| hub_valid | input | 1 | Main memory data valid |
| hub_rdata | input | 32 | Main memory read data |
| instr_valid | output | 1 | Instruction delivered this cycle |
| instr | output | 32 | Delivered instruction |
| instr_pc | output | 20 | Byte address of delivered instruction |
| err_sfr | output | 1 | Fetch attempted from reserved registers |
| err_bound | output | 1 | Sequential fetch ran off the top of lookup RAM |
| err_misalign | output | 1 | Local branch target not long-aligned |

## Verification
The hardest case to reach is a branch that arrives while the block is already halted on a boundary error. It takes three steps to set up. First, a branch lands two longs below the top of lookup RAM. Then two sequential fetches run off the end. Then a misaligned branch and a reserved-register branch are issued. The bench follows this order so that it can show three things at the ports: a rejected branch keeps the halt and the boundary flag, an accepted branch clears that flag even when it leads into the reserved area, and a later aligned branch restarts fetching. The run from register RAM into lookup RAM is reached by branching to `0x7F8`.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

    typedef enum logic [1:0] {
        RG_SFR,
        RG_REG,
        RG_LUT,
        RG_HUB
    } region_t;

    typedef enum logic [2:0] {
        ST_ISSUE,
        ST_LREQ,
        ST_LDATA,
        ST_HWAIT,
        ST_HALT
    } fstate_t;

endpackage

// File: rtl/fetch_region_decode.sv
module fetch_region_decode
    import fetch_seq_pkg::*;
#(
    parameter int PC_W    = 20,
    parameter int IDX_W   = 9,
    parameter int SFR_CNT = 8
) (
    input  logic [PC_W-1:0]  pc,
    output region_t          rgn,
    output logic [IDX_W-1:0] idx,
    output logic             at_top
);
    localparam int LW          = IDX_W + 1;
    localparam int LOCAL_BYTES = 4 * (2 ** LW);

    logic [LW-1:0] word;
    logic          is_local;

    assign word     = pc[LW+1:2];
    assign is_local = (pc < PC_W'(LOCAL_BYTES));
    assign idx      = word[IDX_W-1:0];
    assign at_top   = &word;

    always_comb begin
        if (!is_local)
            rgn = RG_HUB;
        else if (word < LW'(SFR_CNT))
            rgn = RG_SFR;
        else if (word[LW-1])
            rgn = RG_LUT;
        else
            rgn = RG_REG;
    end

endmodule

// File: rtl/fetch_branch_check.sv
module fetch_branch_check #(
    parameter int PC_W  = 20,
    parameter int IDX_W = 9
) (
    input  logic [PC_W-1:0] target,
    output logic            bad
);
    localparam int LOCAL_BYTES = 4 * (2 ** (IDX_W + 1));

    assign bad = (target < PC_W'(LOCAL_BYTES)) && (target[1:0] != 2'b00);

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter int          PC_W     = 20,
    parameter int          IDX_W    = 9,
    parameter int          DATA_W   = 32,
    parameter int          SFR_CNT  = 8,
    parameter int unsigned RESET_PC = 'h01000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [PC_W-1:0]   br_target,
    output logic              reg_req,
    output logic              lut_req,
    output logic [IDX_W-1:0]  loc_idx,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] lut_rdata,
    output logic              hub_req,
    output logic [PC_W-1:0]   hub_addr,
    input  logic              hub_valid,
    input  logic [DATA_W-1:0] hub_rdata,
    output logic              instr_valid,
    output logic [DATA_W-1:0] instr,
    output logic [PC_W-1:0]   instr_pc,
    output logic              err_sfr,
    output logic              err_bound,
    output logic              err_misalign
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    fstate_t          state, nxt;
    logic [PC_W-1:0]  pc;
    region_t          rgn;
    logic [IDX_W-1:0] idx;
    logic             at_top;
    logic             tgt_bad;
    logic             br_take;

    fetch_region_decode #(.PC_W(PC_W), .IDX_W(IDX_W), .SFR_CNT(SFR_CNT)) u_dec (
        .pc     (pc),
        .rgn    (rgn),
        .idx    (idx),
        .at_top (at_top)
    );

    fetch_branch_check #(.PC_W(PC_W), .IDX_W(IDX_W)) u_bchk (
        .target (br_target),
        .bad    (tgt_bad)
    );

    assign br_take = br_valid && !tgt_bad;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ISSUE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (br_take) begin
            nxt = ST_ISSUE;
        end else begin
            unique case (state)
                ST_ISSUE: begin
                    if (rgn == RG_SFR)      nxt = ST_HALT;
                    else if (rgn == RG_HUB) nxt = ST_HWAIT;
                    else                    nxt = ST_LREQ;
                end
                ST_LREQ:  nxt = ST_LDATA;
                ST_LDATA: nxt = at_top ? ST_HALT : ST_ISSUE;
                ST_HWAIT: nxt = hub_valid ? ST_ISSUE : ST_HWAIT;
                ST_HALT:  nxt = ST_HALT;
                default:  nxt = ST_HALT;
            endcase
        end
    end

    // outputs and program counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc           <= PC_W'(RESET_PC);
            reg_req      <= 1'b0;
            lut_req      <= 1'b0;
            hub_req      <= 1'b0;
            loc_idx      <= '0;
            hub_addr     <= '0;
            instr_valid  <= 1'b0;
            instr        <= '0;
            instr_pc     <= '0;
            err_sfr      <= 1'b0;
            err_bound    <= 1'b0;
            err_misalign <= 1'b0;
        end else begin
            instr_valid <= 1'b0;
            if (br_take) begin
                pc           <= br_target;
                reg_req      <= 1'b0;
                lut_req      <= 1'b0;
                hub_req      <= 1'b0;
                err_sfr      <= 1'b0;
                err_bound    <= 1'b0;
                err_misalign <= 1'b0;
            end else begin
                if (br_valid) err_misalign <= 1'b1;
                unique case (state)
                    ST_ISSUE: begin
                        unique case (rgn)
                            RG_SFR: err_sfr <= 1'b1;
                            RG_REG: begin
                                reg_req <= 1'b1;
                                loc_idx <= idx;
                            end
                            RG_LUT: begin
                                lut_req <= 1'b1;
                                loc_idx <= idx;
                            end
                            RG_HUB: begin
                                hub_req  <= 1'b1;
                                hub_addr <= pc;
                            end
                            default: err_sfr <= 1'b1;
                        endcase
                    end
                    ST_LREQ: begin
                        reg_req <= 1'b0;
                        lut_req <= 1'b0;
                    end
                    ST_LDATA: begin
                        instr       <= (rgn == RG_LUT) ? lut_rdata : reg_rdata;
                        instr_valid <= 1'b1;
                        instr_pc    <= pc;
                        if (at_top) err_bound <= 1'b1;
                        else        pc        <= pc + STEP;
                    end
                    ST_HWAIT: begin
                        if (hub_valid) begin
                            hub_req     <= 1'b0;
                            instr       <= hub_rdata;
                            instr_valid <= 1'b1;
                            instr_pc    <= pc;
                            pc          <= pc + STEP;
                        end
                    end
                    ST_HALT: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
    parameter int PC_W    = 20,
    parameter int IDX_W   = 9,
    parameter int SFR_CNT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_req,
    input logic             lut_req,
    input logic             hub_req,
    input logic             hub_valid,
    input logic             br_valid,
    input logic [PC_W-1:0]  hub_addr,
    input logic [IDX_W-1:0] loc_idx,
    input logic             instr_valid,
    input logic [PC_W-1:0]  instr_pc,
    input logic             err_sfr,
    input logic             err_bound
);
    localparam logic [PC_W-1:0] LOCAL_BYTES = PC_W'(4 * (2 ** (IDX_W + 1)));

    // R3
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_req, lut_req, hub_req}));

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sfr || err_bound) |-> !(reg_req || lut_req || hub_req));

    // R8
    hub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && !hub_valid && !br_valid) |=> (hub_req && $stable(hub_addr)));

    // R4
    local_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (instr_pc < LOCAL_BYTES)) |-> $past(reg_req || lut_req, 2));

    // R8
    hub_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (instr_pc >= LOCAL_BYTES)) |-> $past(hub_valid));

    // R2
    reg_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (loc_idx >= IDX_W'(SFR_CNT)));

endmodule

bind fetch_seq fetch_seq_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .SFR_CNT(SFR_CNT)) u_chk (.*);

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
    localparam int HUB_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [19:0] br_target = '0;
    logic        reg_req, lut_req, hub_req;
    logic [8:0]  loc_idx;
    logic [31:0] reg_rdata = '0, lut_rdata = '0, hub_rdata = '0;
    logic [19:0] hub_addr;
    logic        hub_valid = 1'b0;
    logic        instr_valid;
    logic [31:0] instr;
    logic [19:0] instr_pc;
    logic        err_sfr, err_bound, err_misalign;

    int checks = 0;
    int errors = 0;
    int hub_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
        .reg_req(reg_req), .lut_req(lut_req), .loc_idx(loc_idx),
        .reg_rdata(reg_rdata), .lut_rdata(lut_rdata),
        .hub_req(hub_req), .hub_addr(hub_addr), .hub_valid(hub_valid),
        .hub_rdata(hub_rdata), .instr_valid(instr_valid), .instr(instr),
        .instr_pc(instr_pc), .err_sfr(err_sfr), .err_bound(err_bound),
        .err_misalign(err_misalign)
    );

    // local RAM models: data valid only in the cycle after a request
    always @(posedge clk) begin
        reg_rdata <= reg_req ? (32'hC000_0000 | 32'(loc_idx)) : 32'hBAD0_0000;
        lut_rdata <= lut_req ? (32'hD000_0000 | 32'(loc_idx)) : 32'hBAD1_0000;
    end

    // main memory stream model with fixed latency
    always @(posedge clk) begin
        if (!hub_req || hub_valid) begin
            hub_cnt   <= 0;
            hub_valid <= 1'b0;
        end else if (hub_cnt == HUB_LAT - 1) begin
            hub_valid <= 1'b1;
            hub_rdata <= 32'hE000_0000 | 32'(hub_addr);
        end else begin
            hub_cnt <= hub_cnt + 1;
        end
    end

    function automatic logic [31:0] exp_data(input logic [19:0] pc);
        logic [9:0] w;
        w = pc[11:2];
        if (pc >= 20'h01000) return 32'hE000_0000 | 32'(pc);
        if (w[9])            return 32'hD000_0000 | 32'(w[8:0]);
        return 32'hC000_0000 | 32'(w[8:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_branch(input logic [19:0] t);
        @(negedge clk);
        br_valid  = 1'b1;
        br_target = t;
        @(negedge clk);
        br_valid  = 1'b0;
    endtask

    task automatic expect_fetch(input logic [19:0] pc, input string tag);
        bit got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (instr_valid) got = 1;
        end
        chk(got, {tag, " valid"}, 32'(got), 32'd1);
        chk(instr_pc == pc, {tag, " pc"}, 32'(instr_pc), 32'(pc));
        chk(instr == exp_data(pc), {tag, " data"}, instr, exp_data(pc));
    endtask

    // which: 0 reg, 1 lut, 2 hub
    task automatic wait_req(input int which, input string tag);
        bit got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if ((which == 0 && reg_req) || (which == 1 && lut_req) || (which == 2 && hub_req)) got = 1;
        end
        chk(got, {tag, " request"}, 32'(got), 32'd1);
        chk($countones({reg_req, lut_req, hub_req}) == 1, "R3 one-hot request",
            32'($countones({reg_req, lut_req, hub_req})), 32'd1);
    endtask

    task automatic expect_quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (instr_valid || reg_req || lut_req || hub_req) seen = 1;
        end
        chk(!seen, {tag, " no fetch"}, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!instr_valid && !err_sfr && !err_bound && !err_misalign, "R1 in reset",
            {28'd0, instr_valid, err_sfr, err_bound, err_misalign}, 32'd0);
        rst_n = 1'b1;
        wait_req(2, "R1 first hub");
        chk(hub_addr == 20'h01000, "R1 reset pc", 32'(hub_addr), 32'h01000);
        chk(!err_sfr && !err_bound && !err_misalign, "R1 flags after reset",
            {29'd0, err_sfr, err_bound, err_misalign}, 32'd0);
    endtask

    task automatic t_hub_seq;
        @(negedge clk);
        chk(hub_req && hub_addr == 20'h01000, "R8 hold during stall", 32'(hub_addr), 32'h01000);
        expect_fetch(20'h01000, "R8 hub first");
        expect_fetch(20'h01004, "R5 hub step");
    endtask

    task automatic t_local_seam;
        do_branch(20'h007F8);
        wait_req(0, "R2 reg");
        chk(loc_idx == 9'h1FE, "R2 reg index", 32'(loc_idx), 32'h1FE);
        expect_fetch(20'h007F8, "R4 reg fetch");
        expect_fetch(20'h007FC, "R5 reg step");
        wait_req(1, "R2 lut");
        chk(loc_idx == 9'h000, "R5 seam into lut idx", 32'(loc_idx), 32'h0);
        expect_fetch(20'h00800, "R5 seam fetch");
    endtask

    task automatic t_bound;
        do_branch(20'h00FF8);
        expect_fetch(20'h00FF8, "R7 lut near top");
        expect_fetch(20'h00FFC, "R7 lut top");
        chk(err_bound, "R7 bound flag", 32'(err_bound), 32'd1);
        expect_quiet(10, "R7 after bound");
    endtask

    task automatic t_misalign;
        do_branch(20'h00022);
        chk(err_misalign, "R9 misalign flag", 32'(err_misalign), 32'd1);
        chk(err_bound, "R9 bound kept", 32'(err_bound), 32'd1);
        expect_quiet(8, "R9 target not loaded");
    endtask

    task automatic t_sfr;
        do_branch(20'h0001C);
        @(negedge clk);
        chk(err_sfr, "R6 sfr flag", 32'(err_sfr), 32'd1);
        chk(!err_bound && !err_misalign, "R10 flags cleared",
            {30'd0, err_bound, err_misalign}, 32'd0);
        expect_quiet(8, "R6 sfr");
    endtask

    task automatic t_restart;
        do_branch(20'h00020);
        chk(!err_sfr, "R10 sfr cleared", 32'(err_sfr), 32'd0);
        wait_req(0, "R10 restart");
        chk(loc_idx == 9'h008, "R2 first code reg", 32'(loc_idx), 32'h8);
        expect_fetch(20'h00020, "R10 restart fetch");
    endtask

    task automatic t_hub_unaligned;
        do_branch(20'h12345);
        wait_req(2, "R8 unaligned");
        chk(hub_addr == 20'h12345, "R8 unaligned addr", 32'(hub_addr), 32'h12345);
        expect_fetch(20'h12345, "R8 unaligned fetch");
        expect_fetch(20'h12349, "R5 unaligned step");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_hub_seq();
        t_local_seam();
        t_bound();
        t_misalign();
        t_sfr();
        t_restart();
        t_hub_unaligned();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule